// File: doc/BRIEF.md
# Dual-Channel I/Q Parallel Output Formatter

This block sits at the output of a two-channel digital receiver. It takes one complex sample (an in-phase word and a quadrature word) from each of the receive channels A and B. It places these words one at a time on a single parallel output bus. Three registered strobes go with the bus. The first is a word-valid strobe. The second is an in-phase/quadrature phase flag. The third is a channel flag that tells channel A from channel B. Downstream logic can therefore demultiplex the stream without counting words.

A sample-ready pulse asks for one burst. Each channel offers its word pair through a ready/valid handshake. A burst starts once a request is pending, the bus is free, and every channel the mode needs has valid data. The words are captured at that handshake. Single-channel mode sends two words per burst, channel A I and then channel A Q. Diversity mode sends four words per burst: A's I, A's Q, B's I and B's Q, on consecutive clocks. Requests that arrive during a burst are counted and served one after another with no idle gap, up to a set limit.

Top module: `iq_out_fmt`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dout_vld`, `dout_iq` and `dout_cha` are low and `dout` is zero.
- R2: Whenever `dout_vld` is low, `dout_cha` and `dout_iq` are also low.
- R3: In single-channel mode (`div_mode_i` = 0 at reset), a burst puts out exactly two words. The first is A's I word with `dout_iq`=1 and `dout_cha`=1. The second, on the next clock, is A's Q word with `dout_iq`=0 and `dout_cha`=1. `dout_cha` is never low while `dout_vld` is high.
- R4: In diversity mode (`div_mode_i` = 1 at reset), a burst puts out four words on consecutive clocks, with `dout_vld` high on all four. The order, with its flag pairs (iq,cha), is: A I (1,1), A Q (0,1), B I (1,0), B Q (0,0).
- R5: Timing of a request. Take a `smp_rdy_i` pulse sampled at clock edge N with the needed channel valids already high. A's I word is on the bus after edge N+1, and the handshake ready is high in the cycle between edges N and N+1.
- R6: A burst starts only when `a_vld_i` is high, and in diversity mode also `b_vld_i`. Until then no word is output. `a_rdy_o` is high for exactly the start cycle. `b_rdy_o` is high only in that cycle and only in diversity mode.
- R7: The mode is taken from `div_mode_i` only while `rst` is high. Changes of `div_mode_i` after reset have no effect on burst length.
- R8: A request that arrives during a burst, or before channel data is valid, is held and served later. This also applies to a request sampled in the start cycle itself. Up to `PEND_MAX` (default 3) requests are held. When a request is pending at the last word of a burst, the next burst starts on the following clock with no idle cycle.
- R9: All words of a burst are captured at the start handshake. Input word changes after that cycle do not alter the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_mode_i | input | 1 | 1 = diversity mode, 0 = single-channel mode; sampled during reset |
| smp_rdy_i | input | 1 | One-cycle request for a new output burst |
| a_i_i | input | DW | Channel A in-phase word |
| a_q_i | input | DW | Channel A quadrature word |
| a_vld_i | input | 1 | Channel A word pair valid |
| a_rdy_o | output | 1 | Channel A word pair accepted this cycle |
| b_i_i | input | DW | Channel B in-phase word |
| b_q_i | input | DW | Channel B quadrature word |
| b_vld_i | input | 1 | Channel B word pair valid |
| b_rdy_o | output | 1 | Channel B word pair accepted this cycle |
| dout | output | DW | Output data bus (16 bits by default) |
| dout_vld | output | 1 | Output word valid |
| dout_iq | output | 1 | 1 = in-phase word, 0 = quadrature word |
| dout_cha | output | 1 | 1 = channel A word, 0 = channel B word |

## Verification
A word index that slips shows up on the very next output clock. The flag pair breaks the fixed (1,1),(0,1),(1,0),(0,0) pattern, or a Q word appears without its I word. A lost or doubled request count shows up when a burst of queued requests ends. The number of valid words after the queue is released then differs from twice the held count, within a few clocks. A capture register loaded at the wrong time shows up as a wrong Q or B word one to three clocks after the handshake.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  // word slot within one burst; bit 0 = quadrature, bit 1 = channel B
  typedef enum logic [1:0] {
    SLOT_AI = 2'd0,
    SLOT_AQ = 2'd1,
    SLOT_BI = 2'd2,
    SLOT_BQ = 2'd3
  } slot_e;

  function automatic logic slot_is_i(input logic [1:0] s);
    return ~s[0];
  endfunction

  function automatic logic slot_is_a(input logic [1:0] s);
    return ~s[1];
  endfunction
endpackage

// File: rtl/iqf_pend.sv
module iqf_pend #(
  parameter int PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic take_i,
  output logic has_o
);
  localparam int CW = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(PEND_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({req_i, take_i})
        2'b10:   if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign has_o = (cnt_q != '0);

  // R8
  take_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |-> has_o);
endmodule

// File: rtl/iqf_hold.sv
module iqf_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] a_q_i,
  input  logic [DW-1:0] b_i_i,
  input  logic [DW-1:0] b_q_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] word_o
);
  localparam int NW = 3;

  logic [DW-1:0] src [NW];
  logic [DW-1:0] wq  [NW];

  assign src[0] = a_q_i;
  assign src[1] = b_i_i;
  assign src[2] = b_q_i;

  for (genvar g = 0; g < NW; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)         wq[g] <= '0;
      else if (load_i) wq[g] <= src[g];
    end
  end

  always_comb begin
    case (sel_i)
      2'd1:    word_o = wq[0];
      2'd2:    word_o = wq[1];
      2'd3:    word_o = wq[2];
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/iqf_seq.sv
module iqf_seq
  import iqf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_div_i,
  input  logic          start_i,
  input  logic [DW-1:0] first_word_i,
  input  logic [DW-1:0] held_word_i,
  output logic [1:0]    next_slot_o,
  output logic          free_o,
  output logic [DW-1:0] dout_o,
  output logic          vld_o,
  output logic          iq_o,
  output logic          cha_o
);
  logic [1:0] slot_q;
  logic [1:0] last_slot;
  logic [1:0] nxt;

  assign last_slot   = mode_div_i ? SLOT_BQ : SLOT_AQ;
  assign nxt         = slot_q + 2'd1;
  assign next_slot_o = nxt;
  assign free_o      = !vld_o || (slot_q == last_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_AI;
      vld_o  <= 1'b0;
      iq_o   <= 1'b0;
      cha_o  <= 1'b0;
      dout_o <= '0;
    end else if (start_i) begin
      slot_q <= SLOT_AI;
      vld_o  <= 1'b1;
      iq_o   <= 1'b1;
      cha_o  <= 1'b1;
      dout_o <= first_word_i;
    end else if (vld_o && slot_q != last_slot) begin
      slot_q <= nxt;
      vld_o  <= 1'b1;
      iq_o   <= slot_is_i(nxt);
      cha_o  <= slot_is_a(nxt);
      dout_o <= held_word_i;
    end else begin
      vld_o  <= 1'b0;
      iq_o   <= 1'b0;
      cha_o  <= 1'b0;
      dout_o <= '0;
    end
  end

  // R2
  idle_flags_low_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> (!cha_o && !iq_o));
  // R3
  i_then_q_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_o && iq_o) |=> (vld_o && !iq_o && (cha_o == $past(cha_o))));
  // R3
  single_only_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_div_i && vld_o) |-> cha_o);
  // R4
  a_then_b_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_div_i && vld_o && cha_o && !iq_o) |=> (vld_o && !cha_o && iq_o));
endmodule

// File: rtl/iq_out_fmt.sv
module iq_out_fmt #(
  parameter int DW       = 16,
  parameter int PEND_MAX = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_mode_i,
  input  logic          smp_rdy_i,
  input  logic [DW-1:0] a_i_i,
  input  logic [DW-1:0] a_q_i,
  input  logic          a_vld_i,
  output logic          a_rdy_o,
  input  logic [DW-1:0] b_i_i,
  input  logic [DW-1:0] b_q_i,
  input  logic          b_vld_i,
  output logic          b_rdy_o,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          dout_iq,
  output logic          dout_cha
);
  logic          mode_div_q;
  logic          has_req;
  logic          seq_free;
  logic          start;
  logic [1:0]    nslot;
  logic [DW-1:0] held_word;

  always_ff @(posedge clk) begin
    if (rst) mode_div_q <= div_mode_i;
  end

  assign start   = has_req && seq_free && a_vld_i && (!mode_div_q || b_vld_i);
  assign a_rdy_o = start;
  assign b_rdy_o = start && mode_div_q;

  iqf_pend #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req_i  (smp_rdy_i),
    .take_i (start),
    .has_o  (has_req)
  );

  iqf_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (start),
    .a_q_i  (a_q_i),
    .b_i_i  (b_i_i),
    .b_q_i  (b_q_i),
    .sel_i  (nslot),
    .word_o (held_word)
  );

  iqf_seq #(.DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .mode_div_i   (mode_div_q),
    .start_i      (start),
    .first_word_i (a_i_i),
    .held_word_i  (held_word),
    .next_slot_o  (nslot),
    .free_o       (seq_free),
    .dout_o       (dout),
    .vld_o        (dout_vld),
    .iq_o         (dout_iq),
    .cha_o        (dout_cha)
  );

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode_div_q));
  // R6
  a_rdy_gated_chk: assert property (@(posedge clk) disable iff (rst)
    a_rdy_o |-> a_vld_i);
  // R6
  b_rdy_gated_chk: assert property (@(posedge clk) disable iff (rst)
    b_rdy_o |-> (mode_div_q && b_vld_i && a_rdy_o));
endmodule

// File: tb/iq_out_fmt_test.sv
`timescale 1ns/1ps
module iq_out_fmt_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          div_mode_i = 1'b0;
  logic          smp_rdy_i = 1'b0;
  logic [DW-1:0] a_i_i = '0, a_q_i = '0, b_i_i = '0, b_q_i = '0;
  logic          a_vld_i = 1'b0, b_vld_i = 1'b0;
  logic          a_rdy_o, b_rdy_o;
  logic [DW-1:0] dout;
  logic          dout_vld, dout_iq, dout_cha;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  iq_out_fmt #(.DW(DW), .PEND_MAX(3)) uut (
    .clk(clk), .rst(rst), .div_mode_i(div_mode_i), .smp_rdy_i(smp_rdy_i),
    .a_i_i(a_i_i), .a_q_i(a_q_i), .a_vld_i(a_vld_i), .a_rdy_o(a_rdy_o),
    .b_i_i(b_i_i), .b_q_i(b_q_i), .b_vld_i(b_vld_i), .b_rdy_o(b_rdy_o),
    .dout(dout), .dout_vld(dout_vld), .dout_iq(dout_iq), .dout_cha(dout_cha)
  );

  // stimulus words {ai, aq, bi, bq}; expected stream is the same words in that order
  localparam logic [63:0] VEC [4] = '{
    64'h1111_2222_3333_4444,
    64'hFFFF_0000_8000_7FFF,
    64'h0001_FFFE_A5A5_5A5A,
    64'hC3C3_3C3C_0F0F_F0F0
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packs {vld, iq, cha, data}
  function automatic logic [31:0] obs();
    return {13'd0, dout_vld, dout_iq, dout_cha, dout};
  endfunction

  function automatic logic [31:0] word(input logic v, input logic iq, input logic ca,
                                       input logic [DW-1:0] d);
    return {13'd0, v, iq, ca, d};
  endfunction

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    div_mode_i = mode;
    smp_rdy_i = 1'b0;
    a_vld_i = 1'b0;
    b_vld_i = 1'b0;
    tick();
    tick();
    rst = 1'b0;
    div_mode_i = ~mode;  // R7: later changes must be ignored
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // ---- R1: reset state
    rst = 1'b1;
    tick();
    chk("R1 reset outputs", obs(), 32'd0);
    do_reset(1'b1);
    chk("R1 first cycle after reset", obs(), 32'd0);

    // ---- table walk, diversity mode: R4, R5, R9
    for (int k = 0; k < 4; k++) begin
      a_i_i = VEC[k][63:48]; a_q_i = VEC[k][47:32];
      b_i_i = VEC[k][31:16]; b_q_i = VEC[k][15:0];
      a_vld_i = 1'b1; b_vld_i = 1'b1;
      smp_rdy_i = 1'b1;
      tick();
      smp_rdy_i = 1'b0;
      chk("R5 ready in start cycle", {30'd0, a_rdy_o, b_rdy_o}, 32'd3);
      tick();
      chk("R4 word A-I", obs(), word(1, 1, 1, VEC[k][63:48]));
      a_vld_i = 1'b0; b_vld_i = 1'b0;
      a_i_i = ~a_i_i; a_q_i = ~a_q_i; b_i_i = ~b_i_i; b_q_i = ~b_q_i;
      tick();
      chk("R9 word A-Q kept", obs(), word(1, 0, 1, VEC[k][47:32]));
      tick();
      chk("R4 word B-I", obs(), word(1, 1, 0, VEC[k][31:16]));
      tick();
      chk("R4 word B-Q", obs(), word(1, 0, 0, VEC[k][15:0]));
      tick();
      chk("R2 idle after burst", obs(), 32'd0);
    end

    // ---- R6: diversity waits for channel B valid
    smp_rdy_i = 1'b1; a_vld_i = 1'b1; b_vld_i = 1'b0;
    a_i_i = 16'h1234; a_q_i = 16'h5678; b_i_i = 16'h9ABC; b_q_i = 16'hDEF0;
    tick();
    smp_rdy_i = 1'b0;
    tick(); tick();
    chk("R6 no output without B valid", obs(), 32'd0);
    chk("R6 no ready without B valid", {30'd0, a_rdy_o, b_rdy_o}, 32'd0);
    b_vld_i = 1'b1;
    tick();
    chk("R6 starts once B valid", obs(), word(1, 1, 1, 16'h1234));
    chk("R6 ready drops after start", {30'd0, a_rdy_o, b_rdy_o}, 32'd0);
    a_vld_i = 1'b0; b_vld_i = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R2 idle", obs(), 32'd0);

    // ---- single-channel mode, mode input toggled after reset: R3, R7
    do_reset(1'b0);
    a_i_i = 16'hAAAA; a_q_i = 16'h5555; b_i_i = 16'h0F0F; b_q_i = 16'hF0F0;
    a_vld_i = 1'b1; b_vld_i = 1'b1;
    smp_rdy_i = 1'b1;
    tick();
    smp_rdy_i = 1'b0;
    chk("R6 no B ready in single mode", {30'd0, a_rdy_o, b_rdy_o}, 32'd2);
    tick();
    chk("R3 single A-I", obs(), word(1, 1, 1, 16'hAAAA));
    a_vld_i = 1'b0;
    tick();
    chk("R3 single A-Q", obs(), word(1, 0, 1, 16'h5555));
    tick();
    chk("R7 burst ends after two words", obs(), 32'd0);

    // ---- R8: request during start cycle, back-to-back bursts
    a_i_i = 16'h0101; a_q_i = 16'h0202; a_vld_i = 1'b1;
    smp_rdy_i = 1'b1;
    tick();
    tick();  // start edge; second request sampled here
    chk("R8 first burst A-I", obs(), word(1, 1, 1, 16'h0101));
    smp_rdy_i = 1'b0;
    a_i_i = 16'h0303; a_q_i = 16'h0404;
    tick();
    chk("R9 captured A-Q", obs(), word(1, 0, 1, 16'h0202));
    tick();
    chk("R8 next burst without gap", obs(), word(1, 1, 1, 16'h0303));
    a_vld_i = 1'b0;
    tick();
    chk("R8 next burst A-Q", obs(), word(1, 0, 1, 16'h0404));
    tick();
    chk("R8 idle after queue", obs(), 32'd0);

    // ---- R8: saturation at three held requests
    a_vld_i = 1'b0;
    for (int p = 0; p < 5; p++) begin
      smp_rdy_i = 1'b1;
      tick();
    end
    smp_rdy_i = 1'b0;
    tick();
    chk("R6 held while A invalid", obs(), 32'd0);
    a_vld_i = 1'b1;
    begin
      int nv = 0;
      for (int c = 0; c < 12; c++) begin
        tick();
        if (dout_vld) nv++;
      end
      chk("R8 saturated queue word count", 32'(nv), 32'd6);
    end
    a_vld_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule